// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. The line is sampled on a receive tick that runs at 1, 16 or 64 times the bit rate. A falling edge on an idle line starts a candidate start bit. The receiver confirms the start bit half a bit later, then collects 5 to 8 data bits with the least significant bit first. It checks an optional parity bit and one stop bit. Each finished character goes into a one-entry output holding register and is offered on a valid/ready port.

The consumer takes a character by raising `out_ready` while `out_valid` is high. That transfer empties the holding register. The port has no back-pressure toward the line, because the line cannot be paused. If a character finishes while the register still holds one that was not taken, the new character replaces the old one and the overrun flag is set. The parity, framing and overrun flags stay set until the error-clear input is pulsed. A separate detector reports a break, meaning the line held low for two whole frames.

Top module: `async_rx`

## Requirements
- R1: After reset, `out_valid`, `parity_err`, `framing_err`, `overrun_err` and `break_det` are all 0.
- R2: A low level on the line that ends before the half-bit centre check (tick count D/2 after the falling edge is seen, D being the oversampling factor) is dropped. No character is loaded, and the next proper frame is received correctly.
- R3: `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The first data bit received lands in `out_data[0]`. Bits above the character length read as 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data bits. `cfg_par_odd` = 0 selects even parity, meaning data and parity together hold an even number of ones, and 1 selects odd parity. A mismatch sets `parity_err`.
- R5: Only the first stop bit is checked. If it is sampled low, `framing_err` is set and the character is still loaded.
- R6: `out_valid` rises on the clock after the tick that samples the stop bit. It stays high until a cycle in which `out_ready` is 1, and it clears on the next edge.
- R7: If a character finishes while `out_valid` is 1 and `out_ready` is 0, `out_data` takes the new character and `overrun_err` is set.
- R8: `parity_err`, `framing_err` and `overrun_err` are sticky. A one-cycle `err_clear` pulse clears all three. If a new error arrives in the same cycle as the clear, the error is kept.
- R9: `break_det` goes to 1 once the line has been sampled low on 2·F·D consecutive ticks. F is the frame length in bits: start, data, parity and one stop. `break_det` clears on the first tick that samples the line high, or on reset.
- R10: `cfg_rate` = 0 selects D = 1, 1 selects D = 16, and 2 or 3 selects D = 64. With D = 1, every tick samples one bit and the start bit is taken at the tick where the edge is seen.
- R11: While `rx_enable` is 0, the receiver stays idle and no character is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_tick | input | 1 | One-cycle strobe for each receive clock rising edge |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_rate | input | 2 | Oversampling select (1x / 16x / 64x) |
| cfg_len | input | 2 | Character length select (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even parity when 0 |
| rx_enable | input | 1 | Receiver enable |
| err_clear | input | 1 | Clears the sticky error flags |
| out_valid | output | 1 | Holding register has a character |
| out_ready | input | 1 | Consumer takes the character |
| out_data | output | 8 | Received character, zero-extended |
| parity_err | output | 1 | Sticky parity error |
| framing_err | output | 1 | Sticky framing error |
| overrun_err | output | 1 | Sticky overrun |
| break_det | output | 1 | Line held low for two frames |

## Verification
Each character result (`out_valid`, `out_data` and the parity and framing flags) is due on the clock edge just after the tick that samples the stop-bit centre. That tick lies D/2 + (F−1)·D ticks after the edge is seen. `break_det` changes one edge after the tick that carries the threshold sample or the first high sample. `out_valid` drops one edge after the cycle in which `out_ready` is accepted. The bench counts receive ticks at rising edges and changes the line only on falling edges. It checks the character results at a falling edge after the stop bit plus spare idle ticks. It checks break exactly one and zero ticks either side of the 2·F·D threshold.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // Oversampling factor selected by the rate code
  function automatic logic [6:0] rate_div(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd1;
      2'd1:    return 7'd16;
      default: return 7'd64;
    endcase
  endfunction

  // Number of data bits selected by the length code
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             rxd,
  input  logic             line_q,
  input  logic [DIV_W-1:0] div,
  input  logic [IDX_W-1:0] nbits,
  input  logic             par_en,
  output logic             frame_start,
  output logic             data_stb,
  output logic             par_stb,
  output logic             stop_stb
);

  rx_state_e        state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic [IDX_W-1:0] idx;
  logic             edge_seen;
  logic             at_sample;

  assign half      = div >> 1;
  assign edge_seen = !rxd && line_q;
  assign at_sample = enable && tick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else if (!enable) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (edge_seen) begin
            idx <= '0;
            if (half == '0) begin
              state <= ST_DATA;
              cnt   <= div - 1'b1;
            end else begin
              state <= ST_START;
              cnt   <= half - 1'b1;
            end
          end
        end
        ST_START: begin
          if (cnt == '0) begin
            if (!rxd) begin
              state <= ST_DATA;
              cnt   <= div - 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == '0) begin
            cnt <= div - 1'b1;
            idx <= idx + 1'b1;
            if (idx == nbits - 1'b1) state <= par_en ? ST_PAR : ST_STOP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt == '0) begin
            cnt   <= div - 1'b1;
            state <= ST_STOP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    frame_start = enable && tick &&
                  (((state == ST_IDLE) && edge_seen && (half == '0)) ||
                   ((state == ST_START) && (cnt == '0) && !rxd));
    data_stb    = at_sample && (state == ST_DATA);
    par_stb     = at_sample && (state == ST_PAR);
    stop_stb    = at_sample && (state == ST_STOP);
  end

endmodule

// File: rtl/async_rx_shift.sv
module async_rx_shift #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              data_stb,
  input  logic              par_stb,
  input  logic              stop_stb,
  input  logic              rxd,
  input  logic [IDX_W-1:0]  nbits,
  input  logic              par_odd,
  output logic              char_done,
  output logic [DATA_W-1:0] char_data,
  output logic              char_perr,
  output logic              char_ferr
);

  logic [DATA_W-1:0] shreg;
  logic              ones_acc;
  logic              perr_q;
  logic [IDX_W-1:0]  align;

  assign align = IDX_W'(DATA_W) - nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      ones_acc <= 1'b0;
      perr_q   <= 1'b0;
    end else begin
      if (frame_start) begin
        shreg    <= '0;
        ones_acc <= 1'b0;
        perr_q   <= 1'b0;
      end
      if (data_stb) begin
        shreg    <= {rxd, shreg[DATA_W-1:1]};
        ones_acc <= ones_acc ^ rxd;
      end
      if (par_stb) perr_q <= ones_acc ^ rxd ^ par_odd;
    end
  end

  // Bits enter at the top, so a short character is moved down to bit 0
  assign char_done = stop_stb;
  assign char_data = shreg >> align;
  assign char_perr = perr_q;
  assign char_ferr = !rxd;

endmodule

// File: rtl/async_rx_outbuf.sv
module async_rx_outbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_done,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              out_ready,
  input  logic              err_clear,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              parity_err,
  output logic              framing_err,
  output logic              overrun_err
);

  logic taken;
  assign taken = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      if (err_clear) begin
        parity_err  <= 1'b0;
        framing_err <= 1'b0;
        overrun_err <= 1'b0;
      end
      if (char_done) begin
        out_valid <= 1'b1;
        out_data  <= char_data;
        if (char_perr)  parity_err  <= 1'b1;
        if (char_ferr)  framing_err <= 1'b1;
        if (out_valid && !out_ready) overrun_err <= 1'b1;
      end else if (taken) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/async_rx_break.sv
module async_rx_break #(
  parameter int BRK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic [BRK_W-1:0] thr,
  output logic             break_det
);

  logic [BRK_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      break_det <= 1'b0;
    end else if (tick) begin
      if (rxd) begin
        low_cnt   <= '0;
        break_det <= 1'b0;
      end else begin
        if (low_cnt < thr) low_cnt <= low_cnt + 1'b1;
        if (low_cnt + 1'b1 >= thr) break_det <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/async_rx.sv
module async_rx
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 7,
  parameter int BRK_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_tick,
  input  logic              rxd,
  input  logic [1:0]        cfg_rate,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              rx_enable,
  input  logic              err_clear,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              parity_err,
  output logic              framing_err,
  output logic              overrun_err,
  output logic              break_det
);

  localparam int IDX_W = $clog2(DATA_W + 1);

  logic [DIV_W-1:0] div;
  logic [IDX_W-1:0] nbits;
  logic [IDX_W-1:0] frame_bits;
  logic [BRK_W-1:0] brk_thr;
  logic             line_q;
  logic             frame_start, data_stb, par_stb, stop_stb;
  logic             char_done, char_perr, char_ferr;
  logic [DATA_W-1:0] char_data;

  assign div        = DIV_W'(rate_div(cfg_rate));
  assign nbits      = IDX_W'(char_bits(cfg_len));
  assign frame_bits = nbits + IDX_W'(2) + IDX_W'(cfg_par_en);
  assign brk_thr    = BRK_W'({frame_bits, 1'b0}) * BRK_W'(div);

  // Line level at the previous tick, used to find falling edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= 1'b1;
    else if (rx_tick) line_q <= rxd;
  end

  async_rx_ctrl #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (rx_tick),
    .enable      (rx_enable),
    .rxd         (rxd),
    .line_q      (line_q),
    .div         (div),
    .nbits       (nbits),
    .par_en      (cfg_par_en),
    .frame_start (frame_start),
    .data_stb    (data_stb),
    .par_stb     (par_stb),
    .stop_stb    (stop_stb)
  );

  async_rx_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .data_stb    (data_stb),
    .par_stb     (par_stb),
    .stop_stb    (stop_stb),
    .rxd         (rxd),
    .nbits       (nbits),
    .par_odd     (cfg_par_odd),
    .char_done   (char_done),
    .char_data   (char_data),
    .char_perr   (char_perr),
    .char_ferr   (char_ferr)
  );

  async_rx_outbuf #(.DATA_W(DATA_W)) u_outbuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_done   (char_done),
    .char_data   (char_data),
    .char_perr   (char_perr),
    .char_ferr   (char_ferr),
    .out_ready   (out_ready),
    .err_clear   (err_clear),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .parity_err  (parity_err),
    .framing_err (framing_err),
    .overrun_err (overrun_err)
  );

  async_rx_break #(.BRK_W(BRK_W)) u_break (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (rx_tick),
    .rxd       (rxd),
    .thr       (brk_thr),
    .break_det (break_det)
  );

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_tick,
  input logic              rxd,
  input logic              rx_enable,
  input logic [1:0]        cfg_len,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              overrun_err,
  input logic              break_det
);

  // R6
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R7
  overrun_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(out_valid));

  // R3
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ((out_data >> (4'd5 + {2'b00, cfg_len})) == '0));

  // R9
  break_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(break_det) |-> $past(rx_tick && !rxd));

  // R9
  break_clears_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick && rxd) |=> !break_det);

  // R11
  disabled_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !out_valid) |=> !out_valid);

endmodule

bind async_rx async_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_tick     (rx_tick),
  .rxd         (rxd),
  .rx_enable   (rx_enable),
  .cfg_len     (cfg_len),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .overrun_err (overrun_err),
  .break_det   (break_det)
);

// File: tb/async_rx_tb.sv
module async_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_tick = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] cfg_rate = 2'd1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rx_enable = 1'b1;
  logic       err_clear = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       parity_err, framing_err, overrun_err, break_det;

  int total = 0;
  int bad = 0;
  int tick_every = 1;
  int cyc = 0;

  always #5 clk = ~clk;

  async_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rxd(rxd),
    .cfg_rate(cfg_rate), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .rx_enable(rx_enable), .err_clear(err_clear),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .parity_err(parity_err), .framing_err(framing_err),
    .overrun_err(overrun_err), .break_det(break_det)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    rx_tick <= ((cyc + 1) % tick_every) == 0;
  end

  function automatic int ovs(input logic [1:0] r);
    return (r == 2'd0) ? 1 : (r == 2'd1) ? 16 : 64;
  endfunction

  function automatic logic [7:0] len_mask(input logic [1:0] l);
    return 8'hFF >> (3 - l);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (rx_tick) k++;
    end
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int d_ovs = ovs(cfg_rate);
    int nb = 5 + cfg_len;
    logic [7:0] dm = d & len_mask(cfg_len);
    rxd = 1'b0;
    wait_ticks(d_ovs);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      wait_ticks(d_ovs);
    end
    if (cfg_par_en) begin
      rxd = (^dm) ^ cfg_par_odd ^ bad_par;
      wait_ticks(d_ovs);
    end
    rxd = !bad_stop;
    wait_ticks(d_ovs);
    rxd = 1'b1;
    wait_ticks(d_ovs + 2);
  endtask

  task automatic take_char();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic pulse_clear();
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(out_valid == 0, "R1", "out_valid", out_valid, 0);
    check({parity_err, framing_err, overrun_err} == 0, "R1", "error flags",
          {parity_err, framing_err, overrun_err}, 0);
    check(break_det == 0, "R1", "break_det", break_det, 0);

    // R2 glitch shorter than half a bit at 16x
    cfg_rate = 2'd1; cfg_len = 2'd3; cfg_par_en = 0;
    rxd = 1'b0; wait_ticks(5);
    rxd = 1'b1; wait_ticks(40);
    check(out_valid == 0, "R2", "valid after glitch", out_valid, 0);
    send_frame(8'h3C, 0, 0);
    check(out_valid == 1 && out_data == 8'h3C, "R2", "frame after glitch", out_data, 8'h3C);
    take_char();
    // R6 handshake clears valid
    check(out_valid == 0, "R6", "valid after take", out_valid, 0);

    // R10 1x mode with sparse ticks, R4 odd parity ok
    tick_every = 3; cfg_rate = 2'd0; cfg_par_en = 1; cfg_par_odd = 1;
    wait_ticks(2);
    send_frame(8'hA5, 0, 0);
    check(out_valid == 1 && out_data == 8'hA5, "R10", "1x data", out_data, 8'hA5);
    check(parity_err == 0, "R4", "odd parity good", parity_err, 0);
    take_char();

    // R11 disabled receiver loads nothing
    tick_every = 1; cfg_rate = 2'd1; cfg_par_en = 0;
    rx_enable = 1'b0;
    send_frame(8'h55, 0, 0);
    check(out_valid == 0, "R11", "valid while disabled", out_valid, 0);
    rx_enable = 1'b1;
    wait_ticks(2);

    // R7 overrun: two frames without taking
    cfg_len = 2'd2;
    send_frame(8'h11, 0, 0);
    send_frame(8'h6E, 0, 0);
    check(out_valid == 1 && out_data == 8'h6E, "R7", "overwritten data", out_data, 8'h6E);
    check(overrun_err == 1, "R7", "overrun flag", overrun_err, 1);
    take_char();
    check(overrun_err == 1, "R8", "overrun sticky", overrun_err, 1);
    pulse_clear();
    check(overrun_err == 0, "R8", "overrun cleared", overrun_err, 0);

    // R9 break threshold: 16x, 8 bits, parity -> F=11, 352 ticks
    cfg_len = 2'd3; cfg_par_en = 1; cfg_par_odd = 0;
    rxd = 1'b0;
    wait_ticks(351);
    check(break_det == 0, "R9", "break one tick early", break_det, 0);
    wait_ticks(1);
    check(break_det == 1, "R9", "break at threshold", break_det, 1);
    // R5 the all-low frame loads with a framing error
    check(out_valid == 1 && out_data == 8'h00, "R5", "break char data", out_data, 0);
    check(framing_err == 1 && parity_err == 0, "R5", "break char flags",
          {parity_err, framing_err}, 1);
    rxd = 1'b1;
    wait_ticks(1);
    check(break_det == 0, "R9", "break cleared by high", break_det, 0);
    take_char();
    pulse_clear();
    check(framing_err == 0, "R8", "framing cleared", framing_err, 0);
    wait_ticks(4);

    // Constrained random frames
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d = 8'($urandom);
      bit bp, bs;
      logic [7:0] expd;
      tick_every = ($urandom % 3 == 0) ? 2 : 1;
      cfg_rate = ($urandom % 8 == 0) ? 2'd2 : 2'($urandom % 2);
      cfg_len = 2'($urandom);
      cfg_par_en = 1'($urandom);
      cfg_par_odd = 1'($urandom);
      bp = cfg_par_en && ($urandom % 5 == 0);
      bs = ($urandom % 6 == 0);
      expd = d & len_mask(cfg_len);
      wait_ticks(2);
      send_frame(d, bp, bs);
      // R3 length and zero-fill
      check(out_valid == 1 && out_data == expd, "R3", "random data", out_data, expd);
      // R4 parity flag
      check(parity_err == bp, "R4", "parity flag", parity_err, bp);
      // R5 framing flag
      check(framing_err == bs, "R5", "framing flag", framing_err, bs);
      check(overrun_err == 0, "R7", "no overrun", overrun_err, 0);
      take_char();
      check(out_valid == 0, "R6", "valid after take", out_valid, 0);
      if (bp || bs) begin
        pulse_clear();
        check({parity_err, framing_err} == 0, "R8", "flags cleared",
              {parity_err, framing_err}, 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule